// File: doc/BRIEF.md
# Per-Core Countdown Interrupt Timer

A 32-bit countdown timer that software controls through four memory-mapped registers. A write to the start-count register loads the running counter and arms it. The counter then steps down once per prescaled clock tick. When it expires, the block emits a single-cycle interrupt request together with an 8-bit vector. The control register holds the vector, a suppress (mask) bit and a repeat bit. With repeat set, the counter restarts from the start count every time it expires. With repeat clear, it fires once and then parks at zero.

The prescaler divides the bus clock by a power of two from 1 to 128. The divide is chosen by a 4-bit code whose bits 3, 1 and 0 are decoded and whose bit 2 is ignored. The block sits on a simple single-cycle register port. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the control register reads 0x0001_0000 (suppress set), the start-count, live-count and divide registers read zero, and `irq_o` is low.
- R2: Register offsets are: control 0x320, start count 0x380, live count 0x390, divide 0x3E0. Unmapped offsets read zero. Control keeps only bit 17 (repeat), bit 16 (suppress) and bits 7:0 (vector), and its other bits read zero. Divide keeps only bits 3, 1 and 0, and bit 2 reads zero.
- R3: The divide code selects the tick period D in bus clocks: 0x0=2, 0x1=4, 0x2=8, 0x3=16, 0x8=32, 0x9=64, 0xA=128, 0xB=1.
- R4: Writing a start count N≠0 loads the live count with N at that edge and restarts the prescaler. The first `irq_o` is seen exactly N·D clock edges after the write edge.
- R5: With repeat clear, the counter fires once, then the live count stays at zero and no further request is made until the start count is written again.
- R6: With repeat set, the live count reloads the start count on expiry, and requests recur every N·D clock edges.
- R7: `irq_o` is high for exactly one cycle per expiry (when N·D>1), and `irq_vec_o` carries the control register's vector during that cycle.
- R8: While suppress is set, no request is made, but the live count keeps stepping and reloading.
- R9: Writing zero to the start count stops the timer. The live count becomes zero and no request follows.
- R10: The live-count register is read-only. A write to offset 0x390 changes neither its value nor its counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector that goes with `irq_o` |

## Verification
The hardest case to reach is the timing of expiry under the slow divide codes. A one-cycle error in where the prescaler phase restarts only shows up as an interval of N·D±1 edges. The bench therefore counts clock edges from the write edge to the pulse, for every divide code and for random start counts, and repeats the count across several periodic reloads.

A second hard case is counting under suppression, which leaves nothing on `irq_o`. The bench reads the live count at a known edge while suppressed instead. It also writes the live-count offset mid-countdown to show that the value keeps stepping normally.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned MAX_SH  = 7;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h320;
  localparam logic [ADDR_W-1:0] OFS_START = 12'h380;
  localparam logic [ADDR_W-1:0] OFS_LIVE  = 12'h390;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h3E0;

  localparam int unsigned SUPPRESS_BIT = 16;
  localparam int unsigned REPEAT_BIT   = 17;

  typedef struct packed {
    logic             repeat_en;
    logic             suppress;
    logic [VEC_W-1:0] vec;
  } ctrl_t;

  // code {b3,b1,b0}: 0..6 -> /2../128, 7 -> /1
  function automatic logic [CODE_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/tick_regfile.sv
module tick_regfile
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  start_o,
  output logic [CODE_W-1:0] code_o,
  output logic              start_wr_o
);
  assign start_wr_o = wr_en_i && (addr_i == OFS_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '{repeat_en: 1'b0, suppress: 1'b1, vec: '0};
      start_o <= '0;
      code_o  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFS_CTRL: ctrl_o <= '{repeat_en: wdata_i[REPEAT_BIT],
                              suppress:  wdata_i[SUPPRESS_BIT],
                              vec:       wdata_i[VEC_W-1:0]};
        OFS_START: start_o <= wdata_i[CNT_W-1:0];
        OFS_DIV:   code_o  <= {wdata_i[3], wdata_i[1], wdata_i[0]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [MAX_SH-1:0] phase_q;
  logic [MAX_SH-1:0] wrap_mask;

  assign wrap_mask = ~({MAX_SH{1'b1}} << code_to_shift(code_i));
  assign tick_o    = (phase_q & wrap_mask) == wrap_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             repeat_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire_o = !load_i && tick_i && (cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (load_i)               cnt_o <= load_val_i;
    else if (expire_o)             cnt_o <= repeat_i ? reload_i : '0;
    else if (tick_i && cnt_o != 0) cnt_o <= cnt_o - ONE;
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  start_val;
  logic [CNT_W-1:0]  live_cnt;
  logic [CODE_W-1:0] div_code;
  logic              start_wr;
  logic              tick;
  logic              expire;

  tick_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl_q), .start_o(start_val), .code_o(div_code), .start_wr_o(start_wr)
  );

  tick_prescaler u_presc (
    .clk_i, .rst_ni, .clr_i(start_wr), .code_i(div_code), .tick_o(tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(start_wr), .load_val_i(wdata_i[CNT_W-1:0]),
    .tick_i(tick), .repeat_i(ctrl_q.repeat_en), .reload_i(start_val),
    .cnt_o(live_cnt), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o     <= expire && !ctrl_q.suppress;
      irq_vec_o <= ctrl_q.vec;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[REPEAT_BIT]   = ctrl_q.repeat_en;
        rdata_o[SUPPRESS_BIT] = ctrl_q.suppress;
        rdata_o[VEC_W-1:0]    = ctrl_q.vec;
      end
      OFS_START: rdata_o[CNT_W-1:0] = start_val;
      OFS_LIVE:  rdata_o[CNT_W-1:0] = live_cnt;
      OFS_DIV:   rdata_o[3:0] = {div_code[2], 1'b0, div_code[1:0]};
      default: ;
    endcase
  end
endmodule

// File: rtl/core_tick_timer_chk.sv
module core_tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [CNT_W-1:0]  start_val,
  input ctrl_t             ctrl_q,
  input logic              tick
);
  logic wr_start, wr_live;
  assign wr_start = wr_en_i && (addr_i == OFS_START);
  assign wr_live  = wr_en_i && (addr_i == OFS_LIVE);

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> live_cnt == $past(wdata_i[CNT_W-1:0]));

  // R9
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_start && wdata_i[CNT_W-1:0] == 0) |=> (live_cnt == 0 && !irq_o));

  // R5
  oneshot_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.repeat_en && live_cnt == 0 && !wr_start) |=> live_cnt == 0);

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.repeat_en && tick && live_cnt == 1 && !wr_start) |=> live_cnt == $past(start_val));

  // R7
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(live_cnt) == 1 && $past(tick)));

  // R8
  suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(ctrl_q.suppress));

  // R10
  live_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_live && !tick) |=> $stable(live_cnt));
endmodule

bind core_tick_timer core_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .irq_o,
  .live_cnt(live_cnt), .start_val(start_val), .ctrl_q(ctrl_q), .tick(tick)
);

// File: tb/core_tick_timer_tb.sv
`timescale 1ns/1ps
module core_tick_timer_tb;
  localparam time CLK_P = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic [7:0]  irq_vec_o;

  int n_run = 0;
  int n_fail = 0;

  core_tick_timer u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  localparam logic [11:0] A_CTRL = 12'h320, A_START = 12'h380,
                          A_LIVE = 12'h390, A_DIV = 12'h3E0;

  function automatic int div_of(input logic [3:0] c);
    int sh;
    sh = ({c[3], c[1], c[0]} + 1) % 8;
    return 1 << sh;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_irq(output int cnt, output logic [7:0] vec);
    cnt = 0;
    do begin
      @(negedge clk_i);
      cnt++;
    end while (!irq_o && cnt < 20000);
    vec = irq_vec_o;
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (irq_o) seen++;
    end
    check(tag, seen, 0);
  endtask

  logic [3:0] codes [8] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB};

  initial begin
    logic [31:0] d;
    int cnt;
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(A_CTRL, d);  check("R1 ctrl", d, 32'h0001_0000);
    rd(A_START, d); check("R1 start", d, 0);
    rd(A_LIVE, d);  check("R1 live", d, 0);
    rd(A_DIV, d);   check("R1 div", d, 0);
    check("R1 irq", irq_o, 0);

    // R2 field retention and unmapped reads
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R2 ctrl bits", d, 32'h0003_00FF);
    wr(A_DIV, 32'hFFFF_FFFF);  rd(A_DIV, d);  check("R2 div bits", d, 32'hB);
    wr(A_START, 32'h1234);     rd(A_START, d); check("R2 start", d, 32'h1234);
    wr(A_START, 0);
    rd(12'h324, d); check("R2 unmapped", d, 0);

    // R3 R4 R7: every divide code, one-shot
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, 32'h40 + i);
      wr(A_DIV, {28'd0, codes[i]});
      wr(A_START, 3);
      wait_irq(cnt, v);
      check($sformatf("R3 R4 interval code %0h", codes[i]), cnt, 3 * div_of(codes[i]));
      check("R7 vector", v, 8'h40 + i);
      @(negedge clk_i);
      check("R7 one cycle", irq_o, 0);
    end

    // R5 one-shot parks at zero
    rd(A_LIVE, d); check("R5 live zero", d, 0);
    quiet(600, "R5 no repeat");

    // R6 periodic
    wr(A_DIV, 32'hB);
    wr(A_CTRL, 32'h0002_0021);
    wr(A_START, 4);
    for (int k = 0; k < 3; k++) begin
      wait_irq(cnt, v);
      check("R6 period", cnt, 4);
      check("R7 vec periodic", v, 8'h21);
    end

    // R9 stop
    wr(A_START, 0);
    rd(A_LIVE, d); check("R9 live zero", d, 0);
    quiet(40, "R9 no irq");

    // R8 suppress: counting continues silently
    wr(A_CTRL, 32'h0003_0055);
    wr(A_START, 5);
    repeat (3) @(negedge clk_i);
    rd(A_LIVE, d); check("R8 counting", d, 2);
    repeat (3) @(negedge clk_i);
    rd(A_LIVE, d); check("R8 reloaded", d, 4);
    quiet(30, "R8 suppressed");

    // R10 live count is read-only
    wr(A_CTRL, 32'h0000_0010);
    wr(A_START, 100);
    wr(A_LIVE, 32'h5);
    rd(A_LIVE, d); check("R10 running", d, 99);
    wr(A_START, 0);
    wr(A_LIVE, 32'h77);
    rd(A_LIVE, d); check("R10 stopped", d, 0);

    // randomized intervals
    for (int it = 0; it < 20; it++) begin
      logic [3:0] c;
      int n;
      logic rep;
      logic [7:0] vv;
      c   = codes[$urandom % 8];
      n   = 1 + $urandom % 12;
      rep = $urandom % 2;
      vv  = $urandom;
      wr(A_DIV, {28'd0, c});
      wr(A_CTRL, {14'd0, rep, 1'b0, 8'd0, vv});
      wr(A_START, n);
      wait_irq(cnt, v);
      check("R4 random interval", cnt, n * div_of(c));
      check("R7 random vec", v, vv);
      if (rep) begin
        wait_irq(cnt, v);
        check("R6 random period", cnt, n * div_of(c));
      end
      wr(A_START, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule